// File: doc/BRIEF.md
# Capture/Compare Up-Counter with Selectable Trigger Edges

This block is a parameterised up-counter with a single register that acts either as a compare value or as a capture latch. Two asynchronous trigger pins, a primary and a secondary, first pass through a synchroniser. Each pin then has its own 2-bit edge-select field. The counter runs while `run_i` is high. It has three operating modes: free-running, return to zero when the count equals the compare value, and return to zero on a valid edge of the primary pin.

In compare mode, a match raises a one-cycle interrupt pulse. A compare value of zero is handled specially:

- In the match-clear mode it is an illegal setting, and the block reports it on an error output.
- In the other modes it fires on the first step out of zero after a wrap.

In capture mode, a valid edge on the selected pin copies the running count into the register and raises the same interrupt pulse. When the primary pin is the capture source, its edge coding is inverted: a configured falling edge captures on a rising edge, a configured rising edge captures on a falling edge, and the both-edges code disables capture. A one-cycle overflow pulse marks each wrap from all-ones to zero.

Top module: `captimer`

## Requirements
- R1: After reset, `count_o`, `reg_o`, `irq_o` and `ovf_o` are all zero.
- R2: While `run_i` is high the count rises by one per clock. While it is low the count holds. The count wraps from all-ones to zero, and `ovf_o` is high for exactly the one cycle in which `count_o` shows that zero.
- R3: In compare mode (`cap_mode_i`=0) with free-running mode (`mode_i`=00) and a non-zero compare value C, `irq_o` pulses for one cycle. The pulse falls in the cycle in which `count_o` shows C+1 (modulo the counter width).
- R4: In match-clear mode (`mode_i`=01) with a non-zero compare value C, the count returns to zero after the cycle in which it equals C, giving a period of C+1 cycles. `irq_o` is high in each cycle in which `count_o` shows that zero.
- R5: In match-clear mode with a compare value of zero, `cfg_err_o` is high and no interrupt is raised.
- R6: In free-running or edge-clear mode (`mode_i`=10) with a compare value of zero, `irq_o` pulses in the cycle in which `count_o` shows 1. This happens only after a wrap, never on the first step after reset.
- R7: Writing a compare value below the current count causes no early clear. The count runs up to all-ones, wraps (`ovf_o`), and only then matches the new value.
- R8: With the secondary pin as capture source (`cap_src_i`=0), the edge field codes capture as follows: 00 on falling edges, 01 on rising edges, 11 on both edges.
- R9: With the primary pin as capture source (`cap_src_i`=1), the edge field codes capture as follows: 00 on rising edges, 01 on falling edges, 11 on no edge at all.
- R10: Edge field code 10 produces neither a capture nor a clear on either pin.
- R11: A pin change sampled at clock edge k is detected after edge k+1. At edge k+2, `reg_o` takes the count present in that detection cycle, and `irq_o` rises.
- R12: In edge-clear mode, a valid primary edge clears the count at edge k+2, after which counting resumes from zero. The valid edge uses the plain coding: 00 falling, 01 rising, 11 both.
- R13: A capture trigger detected while `run_i` is low is suppressed: `reg_o` keeps its value and no interrupt is raised.
- R14: `wr_i` loads `wdata_i` into the register. When a write and a capture fall on the same edge, the captured count wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Count enable; low stops the counter |
| mode_i | input | 2 | 00 free-run, 01 clear on match, 10 clear on primary edge, 11 as free-run |
| cap_mode_i | input | 1 | 1 register captures, 0 register compares |
| cap_src_i | input | 1 | Capture source: 1 primary pin, 0 secondary pin |
| pri_edge_i | input | 2 | Primary pin edge-select code |
| sec_edge_i | input | 2 | Secondary pin edge-select code |
| pri_pin_i | input | 1 | Primary trigger pin, asynchronous |
| sec_pin_i | input | 1 | Secondary trigger pin, asynchronous |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | W | Register write data |
| count_o | output | W | Current count |
| reg_o | output | W | Compare value or last captured count |
| irq_o | output | 1 | One-cycle match or capture interrupt |
| ovf_o | output | 1 | One-cycle pulse on wrap to zero |
| cfg_err_o | output | 1 | Zero compare value in match-clear mode |

## Verification
The hardest state to reach from the ports is the zero-compare interrupt. It may fire only on the step out of zero that follows a wrap, so the counter must run through a full period before the event can be checked at all. The bench therefore builds the design with an 8-bit counter, which keeps full wraps short. This makes it practical to sweep every compare value in both free-run and match-clear modes. The same short width lets the bench reach a count above a freshly written compare value and then follow the counter through its wrap. Each edge-code and pin-direction pair is applied after a settle period, so that any edge created while setting up the pin level is over before the edge under test.

// File: rtl/captimer_pkg.sv
package captimer_pkg;

   typedef enum logic [1:0] {
      MODE_FREE  = 2'b00,
      MODE_MATCH = 2'b01,
      MODE_EDGE  = 2'b10,
      MODE_RSVD  = 2'b11
   } tmr_mode_e;

   // plain edge coding: 00 falling, 01 rising, 11 both, 10 none
   function automatic logic edge_valid(input logic [1:0] code,
                                       input logic rise, input logic fall);
      case (code)
         2'b00:   return fall;
         2'b01:   return rise;
         2'b11:   return rise | fall;
         default: return 1'b0;
      endcase
   endfunction

   // primary-pin capture coding: inverted, both-edges disables
   function automatic logic pri_capture(input logic [1:0] code,
                                        input logic rise, input logic fall);
      case (code)
         2'b00:   return rise;
         2'b01:   return fall;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/captimer_sync_edge.sv
module captimer_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   // STAGES synchroniser flops plus one history flop for edge detection
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin_i};
   end

   assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/captimer_counter.sv
module captimer_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o,
   output logic         ovf_o
);
   localparam logic [W-1:0] CNT_MAX = '1;

   logic [W-1:0] cnt_q;
   logic         ovf_q;

   assign wrap_o = run_i & ~clr_i & (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= wrap_o;
         if (run_i) cnt_q <= clr_i ? '0 : cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

endmodule

// File: rtl/captimer_capcmp.sv
module captimer_capcmp
   import captimer_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  tmr_mode_e    mode_i,
   input  logic         cap_mode_i,
   input  logic         cap_trig_i,
   input  logic [W-1:0] cnt_i,
   input  logic         wrap_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] reg_o,
   output logic         match_clr_o,
   output logic         irq_o,
   output logic         cfg_err_o
);
   logic [W-1:0] reg_q;
   logic         zwrap_q;
   logic         irq_q;
   logic         reg_zero, hit_nz, hit_zero, cmp_hit, cap_fire;

   assign reg_zero = (reg_q == '0);
   assign hit_nz   = run_i & ~reg_zero & (cnt_i == reg_q);
   // zero compare matches only on the step out of zero that follows a wrap
   assign hit_zero = run_i & reg_zero & (cnt_i == '0) & zwrap_q
                     & (mode_i != MODE_MATCH);
   assign cmp_hit  = ~cap_mode_i & (hit_nz | hit_zero);
   assign cap_fire = cap_mode_i & run_i & cap_trig_i;

   assign match_clr_o = ~cap_mode_i & (mode_i == MODE_MATCH) & hit_nz;
   assign cfg_err_o   = ~cap_mode_i & (mode_i == MODE_MATCH) & reg_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q   <= '0;
         zwrap_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= cmp_hit | cap_fire;
         if (run_i)         zwrap_q <= wrap_i;
         if (cap_fire)      reg_q   <= cnt_i;
         else if (wr_i)     reg_q   <= wdata_i;
      end
   end

   assign reg_o = reg_q;
   assign irq_o = irq_q;

endmodule

// File: rtl/captimer.sv
module captimer
   import captimer_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [1:0]   mode_i,
   input  logic         cap_mode_i,
   input  logic         cap_src_i,
   input  logic [1:0]   pri_edge_i,
   input  logic [1:0]   sec_edge_i,
   input  logic         pri_pin_i,
   input  logic         sec_pin_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] count_o,
   output logic [W-1:0] reg_o,
   output logic         irq_o,
   output logic         ovf_o,
   output logic         cfg_err_o
);
   localparam int NPINS = 2;
   localparam int PRI   = 0;
   localparam int SEC   = 1;

   if (W < 4) begin : g_bad_w
      $error("captimer: W must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("captimer: SYNC_STAGES must be at least 2");
   end

   tmr_mode_e        mode;
   logic [NPINS-1:0] pins, rise, fall;
   logic             cap_trig, edge_clr, match_clr, clr, wrap;

   assign mode = tmr_mode_e'(mode_i);
   assign pins = {sec_pin_i, pri_pin_i};

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      captimer_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pins[p]),
         .rise_o (rise[p]),
         .fall_o (fall[p])
      );
   end

   assign cap_trig = cap_src_i ? pri_capture(pri_edge_i, rise[PRI], fall[PRI])
                               : edge_valid(sec_edge_i, rise[SEC], fall[SEC]);
   assign edge_clr = (mode == MODE_EDGE) & edge_valid(pri_edge_i, rise[PRI], fall[PRI]);
   assign clr      = match_clr | edge_clr;

   captimer_counter #(.W(W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_i),
      .clr_i  (clr),
      .cnt_o  (count_o),
      .wrap_o (wrap),
      .ovf_o  (ovf_o)
   );

   captimer_capcmp #(.W(W)) u_cc (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run_i),
      .mode_i      (mode),
      .cap_mode_i  (cap_mode_i),
      .cap_trig_i  (cap_trig),
      .cnt_i       (count_o),
      .wrap_i      (wrap),
      .wr_i        (wr_i),
      .wdata_i     (wdata_i),
      .reg_o       (reg_o),
      .match_clr_o (match_clr),
      .irq_o       (irq_o),
      .cfg_err_o   (cfg_err_o)
   );

endmodule

// File: rtl/captimer_chk.sv
module captimer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run_i,
   input logic [1:0]   mode_i,
   input logic         cap_mode_i,
   input logic         wr_i,
   input logic [W-1:0] count_o,
   input logic [W-1:0] reg_o,
   input logic         irq_o,
   input logic         ovf_o,
   input logic         cfg_err_o
);
   localparam logic [W-1:0] CNT_MAX = '1;

   AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> count_o == '0);                                          // R2
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> $stable(count_o));                                      // R2
   AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && mode_i == 2'b00 && count_o != CNT_MAX)
      |=> count_o == W'($past(count_o) + 1'b1));                         // R2
   AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && mode_i == 2'b01 && !cap_mode_i && reg_o != '0 && count_o == reg_o)
      |=> count_o == '0);                                                // R4
   AST_ERR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |=> !irq_o);                                             // R5
   AST_STOP_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !wr_i) |=> $stable(reg_o));                             // R13

endmodule

bind captimer captimer_chk #(.W(W)) u_chk (.*);

// File: tb/test_captimer.sv
module test_captimer;
   localparam int W = 8;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run_i = 1'b0;
   logic [1:0]   mode_i = 2'b00;
   logic         cap_mode_i = 1'b0;
   logic         cap_src_i = 1'b0;
   logic [1:0]   pri_edge_i = 2'b10;
   logic [1:0]   sec_edge_i = 2'b10;
   logic         pri_pin_i = 1'b0;
   logic         sec_pin_i = 1'b0;
   logic         wr_i = 1'b0;
   logic [W-1:0] wdata_i = '0;
   logic [W-1:0] count_o, reg_o;
   logic         irq_o, ovf_o, cfg_err_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   captimer #(.W(W)) i_captimer (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; run_i = 1'b0; wr_i = 1'b0;
      pri_pin_i = 1'b0; sec_pin_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_reg(input int v);
      @(negedge clk);
      wr_i = 1'b1; wdata_i = W'(v);
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   // edge sweep for capture: src 1 primary, 0 secondary; dir 1 rising
   task automatic try_capture(input bit src, input logic [1:0] code, input bit dir);
      logic [W-1:0] snap, exp_v;
      bit fire;
      string tag;
      @(negedge clk);
      cap_src_i = src;
      if (src) begin pri_edge_i = code; pri_pin_i = ~dir; end
      else     begin sec_edge_i = code; sec_pin_i = ~dir; end
      repeat (6) tick();
      snap = reg_o;
      @(negedge clk);
      if (src) pri_pin_i = dir; else sec_pin_i = dir;
      @(posedge clk);
      tick();
      exp_v = count_o;
      tick();
      if (code == 2'b10) fire = 0;
      else if (src) fire = (code == 2'b00 && dir) || (code == 2'b01 && !dir);
      else fire = (code == 2'b11) || (code == 2'b01 && dir) || (code == 2'b00 && !dir);
      tag = (code == 2'b10) ? "R10" : (src ? "R9" : "R8");
      if (fire) begin
         chk(irq_o == 1'b1, tag, irq_o, 1);
         chk(reg_o == exp_v, {tag, "/R11"}, reg_o, exp_v);
      end else begin
         chk(irq_o == 1'b0, tag, irq_o, 0);
         chk(reg_o == snap, tag, reg_o, snap);
      end
   endtask

   task automatic try_clear(input logic [1:0] code, input bit dir);
      logic [W-1:0] v;
      bit clr;
      @(negedge clk);
      pri_edge_i = code; pri_pin_i = ~dir;
      repeat (8) tick();
      @(negedge clk);
      pri_pin_i = dir;
      @(posedge clk);
      tick();
      v = count_o;
      tick();
      clr = (code == 2'b11) || (code == 2'b01 && dir) || (code == 2'b00 && !dir);
      if (clr) chk(count_o == 0, "R12", count_o, 0);
      else     chk(count_o == W'(v + 1), code == 2'b10 ? "R10" : "R12", count_o, W'(v + 1));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] prev, v;
      int cyc, first_cnt;
      bit seen_ovf, seen_irq, early;

      // R1 reset state
      do_reset();
      tick();
      chk(count_o == 0, "R1 count", count_o, 0);
      chk(reg_o == 0, "R1 reg", reg_o, 0);
      chk(irq_o == 0, "R1 irq", irq_o, 0);
      chk(ovf_o == 0, "R1 ovf", ovf_o, 0);

      // R2 counting, wrap and overflow pulse
      cap_mode_i = 1'b1; mode_i = 2'b00;
      @(negedge clk); run_i = 1'b1;
      prev = count_o;
      for (int i = 0; i < M + 40; i++) begin
         tick();
         chk(count_o == W'(prev + 1), "R2 step", count_o, W'(prev + 1));
         chk(ovf_o == (count_o == 0), "R2 ovf", ovf_o, count_o == 0);
         prev = count_o;
      end
      @(negedge clk); run_i = 1'b0;
      tick(); prev = count_o;
      repeat (5) tick();
      chk(count_o == prev, "R2 hold", count_o, prev);

      // R3 free-run compare sweep
      for (int c = 1; c < M; c++) begin
         do_reset();
         cap_mode_i = 1'b0; mode_i = 2'b00;
         write_reg(c);
         @(negedge clk); run_i = 1'b1;
         cyc = 0;
         while (!irq_o && cyc < M + 4) begin tick(); cyc++; end
         chk(irq_o && count_o == W'(c + 1), "R3", count_o, W'(c + 1));
      end

      // R4 match-clear sweep: period C+1, count zero at interrupt
      for (int c = 1; c < M; c++) begin
         do_reset();
         cap_mode_i = 1'b0; mode_i = 2'b01;
         write_reg(c);
         @(negedge clk); run_i = 1'b1;
         cyc = 0;
         while (!irq_o && cyc < M + 4) begin tick(); cyc++; end
         chk(irq_o && count_o == 0, "R4 zero", count_o, 0);
         cyc = 0;
         do begin tick(); cyc++; end while (!irq_o && cyc < M + 4);
         chk(cyc == c + 1, "R4 period", cyc, c + 1);
      end

      // R5 zero compare in match-clear mode
      do_reset();
      cap_mode_i = 1'b0; mode_i = 2'b01;
      tick();
      chk(cfg_err_o == 1'b1, "R5 err", cfg_err_o, 1);
      @(negedge clk); run_i = 1'b1;
      seen_irq = 0;
      repeat (M + 20) begin tick(); if (irq_o) seen_irq = 1; end
      chk(seen_irq == 0, "R5 no irq", seen_irq, 0);
      @(negedge clk); mode_i = 2'b00;
      tick();
      chk(cfg_err_o == 1'b0, "R5 err clear", cfg_err_o, 0);

      // R6 zero compare in free-run and edge-clear modes
      for (int m = 0; m < 2; m++) begin
         do_reset();
         cap_mode_i = 1'b0; mode_i = (m == 0) ? 2'b00 : 2'b10;
         pri_edge_i = 2'b10;
         @(negedge clk); run_i = 1'b1;
         seen_ovf = 0; early = 0; first_cnt = -1;
         for (int i = 0; i < M + 10; i++) begin
            tick();
            if (ovf_o) seen_ovf = 1;
            if (irq_o && first_cnt < 0) begin
               first_cnt = count_o;
               if (!seen_ovf) early = 1;
            end
         end
         chk(early == 0, "R6 not before wrap", early, 0);
         chk(first_cnt == 1, "R6 at one", first_cnt, 1);
      end

      // R7 compare written below current count
      do_reset();
      cap_mode_i = 1'b0; mode_i = 2'b01;
      write_reg(200);
      @(negedge clk); run_i = 1'b1;
      while (count_o != 150) tick();
      write_reg(100);
      seen_ovf = 0; early = 0; cyc = 0;
      while (!irq_o && cyc < 2 * M) begin
         tick(); cyc++;
         if (ovf_o) seen_ovf = 1;
      end
      chk(seen_ovf == 1, "R7 wrapped first", seen_ovf, 1);
      chk(irq_o && count_o == 0, "R7 match", count_o, 0);

      // R8 R9 R10 R11 capture edge table
      do_reset();
      cap_mode_i = 1'b1; mode_i = 2'b00;
      @(negedge clk); run_i = 1'b1;
      for (int s = 0; s < 2; s++)
         for (int code = 0; code < 4; code++)
            for (int d = 0; d < 2; d++)
               try_capture(s[0], 2'(code), d[0]);

      // R11 exact latency from reset-known count
      do_reset();
      cap_mode_i = 1'b1; cap_src_i = 1'b0; sec_edge_i = 2'b01; mode_i = 2'b00;
      repeat (6) tick();
      run_i = 1'b1;            // at a point away from the edge; first step is next edge
      repeat (10) @(posedge clk);
      @(negedge clk); sec_pin_i = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(reg_o == 12, "R11 latency", reg_o, 12);
      chk(irq_o == 1, "R11 irq", irq_o, 1);

      // R12 edge-clear mode
      do_reset();
      cap_mode_i = 1'b0; mode_i = 2'b10;
      write_reg(250);
      @(negedge clk); run_i = 1'b1;
      for (int code = 0; code < 4; code++)
         for (int d = 0; d < 2; d++)
            try_clear(2'(code), d[0]);

      // R13 capture suppressed while stopped
      do_reset();
      cap_mode_i = 1'b1; cap_src_i = 1'b0; sec_edge_i = 2'b01; mode_i = 2'b00;
      @(negedge clk); run_i = 1'b1;
      repeat (20) tick();
      @(negedge clk); run_i = 1'b0;
      repeat (4) tick();
      v = reg_o;
      @(negedge clk); sec_pin_i = 1'b1;
      seen_irq = 0;
      repeat (6) begin tick(); if (irq_o) seen_irq = 1; end
      chk(reg_o == v, "R13 reg kept", reg_o, v);
      chk(seen_irq == 0, "R13 no irq", seen_irq, 0);

      // R14 write, and capture winning over a coincident write
      @(negedge clk); run_i = 1'b1; sec_pin_i = 1'b0;
      repeat (6) tick();
      write_reg(8'h5A);
      tick();
      chk(reg_o == 8'h5A, "R14 write", reg_o, 8'h5A);
      @(negedge clk); sec_pin_i = 1'b1;
      @(posedge clk);
      tick();
      v = count_o;
      @(negedge clk); wr_i = 1'b1; wdata_i = 8'hA5;
      tick();
      chk(reg_o == v, "R14 capture wins", reg_o, v);
      @(negedge clk); wr_i = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule